// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is a single timer channel that generates two pulse-width-modulated outputs sharing one period. An up-counter advances on a tick picked by a clock-select field: the bus clock divided by 2, 8, 32 or 128, or a slow-clock strobe supplied from outside. A period register sets the count at which the counter wraps back to zero. Two duty registers, one for each output, are compared against the counter.

Each output has three action fields in the mode register. One applies on its own duty match, one on the shared period match, and one on a software trigger. Each action is none, set or clear. With these fields the same hardware gives a normal waveform (set on period, clear on duty), an inverted one (the two swapped), or a constant level (compare actions none, level fixed by the software trigger). A command register starts the clock, stops it, and fires the software trigger, which restarts the counter at zero.

Software drives the block through a single-cycle synchronous write port and a combinational read port. The counter value is readable at its own address.

Top module: `wave_timer_chan`

## Requirements
- R1: After reset every readable address returns zero, both outputs are low and the counter is stopped.
- R2: Clock-select code (mode bits [2:0]) 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 bus cycles. Code 4 gives one tick per cycle in which `slow_tick` is high. Codes 5 to 7 give no tick.
- R3: On each tick while running, the counter adds one, or goes to zero if it equals the period register (address 3).
- R4: Mode register (address 0) layout: [4:3] output-A duty action, [6:5] output-A period action, [8:7] output-A trigger action, [10:9] / [12:11] / [14:13] the same three for output B. Action code 0 is none, 1 is set, 2 is clear, and 3 behaves as none. The register reads back as written.
- R5: Output A applies its duty action on a tick where the counter equals duty A (address 1), and its period action on a period match.
- R6: Output B does the same with duty B (address 2), independently of output A.
- R7: When a duty match and a period match fall on the same tick, only the period action is applied.
- R8: Command register (address 4): bit 2 clears the counter and applies both trigger actions at that clock edge; bit 0 starts the counter and bit 1 stops it, and stop wins when both are set. Bit 2 alone leaves the run state as it was.
- R9: While stopped, the counter and both outputs hold their values.
- R10: With both compare actions of an output set to none, the output stays at the level the last trigger gave it (0 % or 100 % duty).
- R11: The counter reads at address 5, and writes there are ignored. The command address and addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle strobe from the slow clock domain |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Read data for `reg_addr` (combinational) |
| wave_a | output | 1 | Output A |
| wave_b | output | 1 | Output B |

## Verification
The embedded properties check every cycle that the counter steps by one or wraps to zero on a period match, clears after a trigger, and holds while stopped. They also check that an output moves only on a match or a trigger, that the period action beats a duty action, and that the run flag changes only through a command write. Only the bench's scenarios can show the actual waveform values: duty and period settings in normal, inverted and constant modes, the reserved action code, the measured tick spacing for each divider, and the read-only and write-ignored addresses.

// File: rtl/wt_pkg.sv
package wt_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_RSV  = 2'd3
  } act_e;

  // bit layout is decoded by software: see R4
  typedef struct packed {
    act_e       b_sw;
    act_e       b_per;
    act_e       b_cmp;
    act_e       a_sw;
    act_e       a_per;
    act_e       a_cmp;
    logic [2:0] sel;
  } mode_t;

  localparam int MODE_W   = $bits(mode_t);
  localparam int NUM_DIV  = 4;
  localparam int DIV_STEP = 2;             // each divider is 4x the previous
  localparam int PRE_W    = 1 + DIV_STEP * (NUM_DIV - 1);
  localparam logic [2:0] SEL_SLOW = 3'd4;

  localparam logic [2:0] ADR_MODE = 3'd0;
  localparam logic [2:0] ADR_DA   = 3'd1;
  localparam logic [2:0] ADR_DB   = 3'd2;
  localparam logic [2:0] ADR_PER  = 3'd3;
  localparam logic [2:0] ADR_CMD  = 3'd4;
  localparam logic [2:0] ADR_CNT  = 3'd5;

  localparam int CMD_RUN  = 0;
  localparam int CMD_STOP = 1;
  localparam int CMD_TRIG = 2;

  // level after applying an action; reserved code leaves it alone
  function automatic logic apply_act(logic cur, act_e act);
    case (act)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      default: return cur;
    endcase
  endfunction

  // low-bit mask of the free-running prescaler for selector code 0..3
  function automatic logic [PRE_W-1:0] div_mask(logic [2:0] sel);
    logic [PRE_W-1:0] m;
    m = '0;
    for (int i = 0; i < PRE_W; i++)
      if (i <= DIV_STEP * int'(sel[1:0])) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler
  import wt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       slow_tick,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             div_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign mask     = div_mask(sel);
  assign div_tick = &(pre_q | ~mask);

  always_comb begin
    if (sel < SEL_SLOW)       tick = div_tick;
    else if (sel == SEL_SLOW) tick = slow_tick;
    else                      tick = 1'b0;
  end

  // R2: fastest divider never ticks two cycles in a row
  a_r2_div2_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel == 3'd0) |=> !(tick && sel == 3'd0));

  // R2: reserved selector codes never tick
  a_r2_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel > SEL_SLOW) |-> !tick);

endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          restart,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output logic          step,
  output logic          wrap
);

  assign step = tick && run;
  assign wrap = step && (cnt == period);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (wrap)    cnt <= '0;
    else if (step)    cnt <= cnt + 1'b1;
  end

  // R8: a trigger leaves the counter at zero
  a_r8_trig_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  // R3: a period match returns the counter to zero
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !restart) |=> (cnt == '0));

  // R3: an ordinary tick moves the counter up by one
  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wrap && !restart) |=> (cnt == $past(cnt) + 1'b1));

  // R9: stopped counter holds
  a_r9_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt));

endmodule

// File: rtl/wt_out_action.sv
module wt_out_action
  import wt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_hit,
  input  logic per_hit,
  input  logic trig,
  input  act_e act_cmp,
  input  act_e act_per,
  input  act_e act_sw,
  output logic level
);

  logic level_d;

  // trigger first, then the period match, then the own duty match (R7)
  always_comb begin
    if (trig)         level_d = apply_act(level, act_sw);
    else if (per_hit) level_d = apply_act(level, act_per);
    else if (cmp_hit) level_d = apply_act(level, act_cmp);
    else              level_d = level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level <= 1'b0;
    else        level <= level_d;
  end

  // R7: on a joint match a set period action wins over the duty action
  a_r7_period_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (per_hit && cmp_hit && !trig && act_per == ACT_SET) |=> level);

  // R9: no event, no change
  a_r9_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_hit && !per_hit && !trig) |=> $stable(level));

  // R8: a clearing trigger action drives the output low
  a_r8_trig_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && act_sw == ACT_CLR) |=> !level);

  // R4: the reserved code never moves the output on a duty-only match
  a_r4_reserved_none: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && !per_hit && !trig && act_cmp == ACT_RSV) |=> $stable(level));

endmodule

// File: rtl/wave_timer_chan.sv
module wave_timer_chan
  import wt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          wave_a,
  output logic          wave_b
);

  localparam int NOUT = 2;

  generate
    if (!(CW == 16 || CW == 32)) begin : g_bad_width
      $error("wave_timer_chan: CW must be 16 or 32");
    end
  endgenerate

  mode_t         mode_q;
  logic [CW-1:0] duty_q [NOUT];
  logic [CW-1:0] per_q;
  logic          run_q;

  logic          cmd_we;
  logic          trig;
  logic          tick;
  logic          step;
  logic          wrap;
  logic [CW-1:0] cnt;

  assign cmd_we = reg_we && (reg_addr == ADR_CMD);
  assign trig   = cmd_we && reg_wdata[CMD_TRIG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      per_q  <= '0;
      run_q  <= 1'b0;
      for (int i = 0; i < NOUT; i++) duty_q[i] <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          ADR_MODE: mode_q    <= mode_t'(reg_wdata[MODE_W-1:0]);
          ADR_DA:   duty_q[0] <= reg_wdata;
          ADR_DB:   duty_q[1] <= reg_wdata;
          ADR_PER:  per_q     <= reg_wdata;
          default: ;
        endcase
      end
      if (cmd_we) begin
        if (reg_wdata[CMD_STOP])     run_q <= 1'b0;
        else if (reg_wdata[CMD_RUN]) run_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      ADR_MODE: reg_rdata = CW'(mode_q);
      ADR_DA:   reg_rdata = duty_q[0];
      ADR_DB:   reg_rdata = duty_q[1];
      ADR_PER:  reg_rdata = per_q;
      ADR_CNT:  reg_rdata = cnt;
      default:  reg_rdata = '0;
    endcase
  end

  wt_prescaler u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (mode_q.sel),
    .slow_tick (slow_tick),
    .tick      (tick)
  );

  wt_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (run_q),
    .restart (trig),
    .period  (per_q),
    .cnt     (cnt),
    .step    (step),
    .wrap    (wrap)
  );

  act_e act_cmp [NOUT];
  act_e act_per [NOUT];
  act_e act_sw  [NOUT];
  logic cmp_hit [NOUT];
  logic level   [NOUT];

  assign act_cmp[0] = mode_q.a_cmp;
  assign act_per[0] = mode_q.a_per;
  assign act_sw[0]  = mode_q.a_sw;
  assign act_cmp[1] = mode_q.b_cmp;
  assign act_per[1] = mode_q.b_per;
  assign act_sw[1]  = mode_q.b_sw;

  generate
    for (genvar g = 0; g < NOUT; g++) begin : g_out
      assign cmp_hit[g] = step && (cnt == duty_q[g]);
      wt_out_action u_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_hit (cmp_hit[g]),
        .per_hit (wrap),
        .trig    (trig),
        .act_cmp (act_cmp[g]),
        .act_per (act_per[g]),
        .act_sw  (act_sw[g]),
        .level   (level[g])
      );
    end
  endgenerate

  assign wave_a = level[0];
  assign wave_b = level[1];

  // R8: the run flag moves only through a command write
  a_r8_run_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(run_q));

  // R8: stop wins over start in the same write
  a_r8_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && reg_wdata[CMD_STOP]) |=> !run_q);

  // R11: the command and spare addresses read zero
  a_r11_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADR_CMD || reg_addr > ADR_CNT) |-> (reg_rdata == '0));

endmodule

// File: tb/wave_timer_chan_test.sv
module wave_timer_chan_test;

  localparam int CW = 16;
  localparam int NA = 0, AS = 1, AC = 2, AR = 3;   // action codes (R4)

  typedef struct packed {
    logic [15:0] mode;
    logic [15:0] da;
    logic [15:0] db;
    logic [15:0] per;
    logic [7:0]  ticks;
    logic [15:0] cnt;
    logic        a;
    logic        b;
  } vec_t;

  // field positions from R4
  function automatic logic [15:0] mk(int sel, int ac, int ap, int as,
                                     int bc, int bp, int bs);
    return 16'(sel | (ac << 3) | (ap << 5) | (as << 7) |
               (bc << 9) | (bp << 11) | (bs << 13));
  endfunction

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    // R5 R6: A normal, B inverted, duty 2 of period 4
    '{mk(4, AC, AS, AS, AS, AC, AC), 16'd2, 16'd2, 16'd4, 8'd2, 16'd2, 1'b1, 1'b0},
    '{mk(4, AC, AS, AS, AS, AC, AC), 16'd2, 16'd2, 16'd4, 8'd3, 16'd3, 1'b0, 1'b1},
    // R3: wrap at the period
    '{mk(4, AC, AS, AS, AS, AC, AC), 16'd2, 16'd2, 16'd4, 8'd5, 16'd0, 1'b1, 1'b0},
    '{mk(4, AC, AS, AS, AS, AC, AC), 16'd2, 16'd2, 16'd4, 8'd8, 16'd3, 1'b0, 1'b1},
    // R6: independent duties
    '{mk(4, AC, AS, AS, AC, AS, AS), 16'd1, 16'd3, 16'd5, 8'd3, 16'd3, 1'b0, 1'b1},
    // R7: duty equals period, period action wins; B untouched
    '{mk(4, AC, AS, AC, NA, NA, NA), 16'd3, 16'd0, 16'd3, 8'd4, 16'd0, 1'b1, 1'b1},
    // R10: constant high A, constant low B
    '{mk(4, NA, NA, AS, NA, NA, AC), 16'd1, 16'd1, 16'd2, 8'd7, 16'd1, 1'b1, 1'b0},
    // R4: reserved code acts as none
    '{mk(4, AR, AR, AS, NA, NA, AR), 16'd1, 16'd1, 16'd5, 8'd3, 16'd3, 1'b1, 1'b0},
    // R2: selector 5 gives no tick
    '{mk(5, AC, AS, AS, AC, AS, AS), 16'd1, 16'd1, 16'd3, 8'd4, 16'd0, 1'b1, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slow_tick = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic          wave_a, wave_b;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wave_timer_chan #(.CW(CW)) uut (
    .clk (clk), .rst_n (rst_n), .slow_tick (slow_tick),
    .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .wave_a (wave_a), .wave_b (wave_b)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [CW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [CW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
    end
  endtask

  // bus cycles between two rising edges of wave_a
  task automatic edge_gap(output int gap);
    int t0, t;
    logic prev;
    t0 = -1; t = 0; gap = -1;
    prev = wave_a;
    while (t < 4000 && gap < 0) begin
      @(negedge clk); t++;
      if (wave_a && !prev) begin
        if (t0 < 0) t0 = t;
        else        gap = t - t0;
      end
      prev = wave_a;
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] d;
    int gap;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 read after reset", d, 0);
    end
    chk("R1 wave_a low", wave_a, 0);
    chk("R1 wave_b low", wave_b, 0);
    pulses(2);
    rd(3'd5, d);
    chk("R1 counter stopped", d, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      wr(3'd0, VEC[v].mode);
      wr(3'd1, VEC[v].da);
      wr(3'd2, VEC[v].db);
      wr(3'd3, VEC[v].per);
      wr(3'd4, 16'h5);
      pulses(int'(VEC[v].ticks));
      rd(3'd5, d);
      chk($sformatf("vec %0d count", v), d, VEC[v].cnt);
      chk($sformatf("vec %0d wave_a", v), wave_a, VEC[v].a);
      chk($sformatf("vec %0d wave_b", v), wave_b, VEC[v].b);
    end

    // R9: stopped channel holds counter and outputs
    wr(3'd0, mk(4, AC, AS, AS, NA, NA, AC));
    wr(3'd1, 16'd2);
    wr(3'd3, 16'd4);
    wr(3'd4, 16'h5);
    pulses(3);
    wr(3'd4, 16'h2);
    pulses(5);
    rd(3'd5, d);
    chk("R9 counter held", d, 3);
    chk("R9 wave_a held", wave_a, 0);

    // R8: start without trigger resumes from the held count
    wr(3'd4, 16'h1);
    pulses(2);
    rd(3'd5, d);
    chk("R8 resumed count", d, 0);
    chk("R8 resumed wave_a", wave_a, 1);

    // R8: start and stop together leave it stopped
    wr(3'd4, 16'h3);
    pulses(3);
    rd(3'd5, d);
    chk("R8 stop wins", d, 0);

    // R8: trigger alone restarts a running counter and applies its action
    wr(3'd4, 16'h1);
    pulses(2);
    rd(3'd5, d);
    chk("R8 running before trigger", d, 2);
    wr(3'd0, mk(4, AC, AS, AC, NA, NA, AC));
    wr(3'd4, 16'h4);
    rd(3'd5, d);
    chk("R8 trigger clears count", d, 0);
    chk("R8 trigger clears wave_a", wave_a, 0);
    pulses(1);
    rd(3'd5, d);
    chk("R8 trigger keeps running", d, 1);

    // R4 / R11: readback and ignored write
    rd(3'd0, d);
    chk("R4 mode readback", d, mk(4, AC, AS, AC, NA, NA, AC));
    rd(3'd4, d);
    chk("R11 command reads zero", d, 0);
    wr(3'd5, 16'h0);
    rd(3'd5, d);
    chk("R11 counter write ignored", d, 1);

    // R2: divider spacing, period 4 ticks
    for (int s = 0; s < 4; s++) begin
      wr(3'd0, mk(s, AC, AS, AS, NA, NA, AC));
      wr(3'd1, 16'd1);
      wr(3'd3, 16'd3);
      wr(3'd4, 16'h5);
      edge_gap(gap);
      chk($sformatf("R2 divider code %0d", s), 32'(gap), 32'(4 * (2 << (2 * s))));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule